// File: doc/BRIEF.md
# Picture-in-Picture Overlay Compositor

This block produces the display-side control plane for a picture-in-picture overlay. Two raster counters run from single-cycle display strobes: one for the pixel within the line and one for the line within the field. From these counters and a set of configuration inputs it decides, for every output pixel, whether the screen shows the live full-screen picture, a plain background, the inside of one of two insets, or the frame drawn around an inset. The decision leaves the block as a source-select code, a fast-blanking flag and a colour code (brightness level and hue) for the background and border areas.

Two insets can be shown at once. A single priority input chooses which one covers the other where they overlap. Each inset has a coarse position: horizontal steps of eight pixel clocks and vertical steps of one line. A common offset moves the whole arrangement in steps of four clocks and one line. Border thickness and the three colour codes are held in small internal registers that are loaded through write strobes. The blanking flag can be moved by half a pixel or a whole pixel relative to the video controls, so that it lines up with downstream switching delays.

Fetching inset pixels from memory and the digital-to-analog conversion are outside this block. Downstream logic uses the select code to steer its own data paths.

Top module: `pip_compositor`

## Requirements
- R1: While reset is high, and on the cycle after it, ovl_sel, ovl_fbl, ovl_bright and ovl_hue are all 0. The border thickness registers reset to code 2 horizontally (4 pixels) and code 2 vertically (2 lines). All three colour registers reset to 0.
- R2: The pixel position x is 0 in the cycle after a cycle with line_strb high, and otherwise counts up by one per clock. The line position y is 0 after field_strb is high, and otherwise counts up by one at each line_strb. Both counters saturate. The outputs for a position appear two clock cycles after the counters hold it.
- R3: The main inset occupies x in [4*off_h + 8*main_hpos, that + main_w) and y in [off_v + main_vpos, that + main_h).
- R4: The sub inset is placed by the same rule, using sub_hpos, sub_vpos, sub_w and sub_h.
- R5: Inside an inset window, a pixel is border when one of these holds: it lies less than 2*bw_h pixels from the left or the right edge, or it lies less than bw_v lines from the top or the bottom edge. Any other pixel in the window is picture. Code 0 gives no border.
- R6: Where both insets cover a pixel, the main inset wins when prio is 0 and the sub inset wins when prio is 1. This applies to both the border and the picture.
- R7: An inset whose enable is 0, or whose width or height is 0, produces neither picture nor border.
- R8: When bg_en is 1, pixels in x [4*off_h, 4*off_h + BG_W) and y [off_v, off_v + BG_H) that no inset covers show background (default size 720 by 240). Otherwise such pixels show the live picture.
- R9: ovl_sel encodes 0 = live picture, 1 = background, 2 = main picture, 3 = sub picture, 4 = main border, 5 = sub border. With blank_shift 0, ovl_fbl is 1 exactly when ovl_sel is not 0.
- R10: A cycle with col_we high loads {col_bright, col_hue} into a colour register chosen by col_sel: 0 = main border, 1 = sub border, 2 = background. col_sel 3 changes no register. {ovl_bright, ovl_hue} carries the matching register for codes 1, 4 and 5, and is 0 for codes 0, 2 and 3.
- R11: A cycle with bw_we high loads bw_h and bw_v into the border thickness registers.
- R12: blank_shift selects how ovl_fbl is timed against ovl_sel. Code 0 gives no shift. Code 1 makes it half a clock late, taken at the falling edge. Code 2 makes it half a clock early. Code 3 makes it one full clock early.

Where a requirement gives a position as "x", "y" or a range, it refers to the counter positions defined in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_strb | input | 1 | One-cycle line start strobe |
| field_strb | input | 1 | One-cycle field start strobe |
| off_h | input | 4 | Common horizontal offset, 4-clock steps |
| off_v | input | 4 | Common vertical offset, 1-line steps |
| main_en | input | 1 | Main inset enable |
| main_hpos | input | 8 | Main inset horizontal position, 8-clock steps |
| main_vpos | input | 8 | Main inset vertical position, lines |
| main_w | input | H_W | Main inset width in pixels |
| main_h | input | V_W | Main inset height in lines |
| sub_en | input | 1 | Sub inset enable |
| sub_hpos | input | 8 | Sub inset horizontal position, 8-clock steps |
| sub_vpos | input | 8 | Sub inset vertical position, lines |
| sub_w | input | H_W | Sub inset width in pixels |
| sub_h | input | V_W | Sub inset height in lines |
| prio | input | 1 | Overlap priority: 0 main on top, 1 sub on top |
| bg_en | input | 1 | Background enable |
| bw_we | input | 1 | Border thickness write strobe |
| bw_h | input | 3 | Horizontal border thickness, 2-pixel units |
| bw_v | input | 3 | Vertical border thickness, lines |
| col_we | input | 1 | Colour register write strobe |
| col_sel | input | 2 | Colour register target |
| col_bright | input | 2 | Brightness level code |
| col_hue | input | 3 | Hue code |
| blank_shift | input | 2 | Fast-blanking timing shift code |
| ovl_sel | output | 3 | Source-select code |
| ovl_fbl | output | 1 | Fast-blanking flag |
| ovl_bright | output | 2 | Brightness code of the shown colour |
| ovl_hue | output | 3 | Hue code of the shown colour |

## Verification
The checker assumes three things about the inputs. line_strb and field_strb are single-cycle pulses, with field_strb always raised together with a line strobe. The strobes are raised on rising edges only. Geometry inputs keep their windows inside the saturating counter range. The stimulus raises the strobes only on the rising clock and keeps every field to a short line length and a few lines. Configuration changes only between runs, and each change is followed by several flush cycles, so the two-stage pipeline never mixes old and new settings in a compared pixel.

// File: rtl/pip_pkg.sv
package pip_pkg;

  typedef enum logic [2:0] {
    SEL_PASS     = 3'd0,
    SEL_BG       = 3'd1,
    SEL_MAIN     = 3'd2,
    SEL_SUB      = 3'd3,
    SEL_MAIN_BDR = 3'd4,
    SEL_SUB_BDR  = 3'd5
  } ovl_sel_e;

  typedef struct packed {
    logic [1:0] bright;
    logic [2:0] hue;
  } tint_t;

  localparam logic [2:0] BW_H_RST = 3'd2;
  localparam logic [2:0] BW_V_RST = 3'd2;

  localparam logic [1:0] TGT_MAIN_BDR = 2'd0;
  localparam logic [1:0] TGT_SUB_BDR  = 2'd1;
  localparam logic [1:0] TGT_BG       = 2'd2;

endpackage

// File: rtl/pip_raster_cnt.sv
module pip_raster_cnt #(
  parameter int H_W = 11,
  parameter int V_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_strb,
  input  logic           field_strb,
  output logic [H_W-1:0] px,
  output logic [V_W-1:0] ln
);

  localparam logic [H_W-1:0] PX_MAX = '1;
  localparam logic [V_W-1:0] LN_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      px <= '0;
    end else if (line_strb) begin
      px <= '0;
    end else if (px != PX_MAX) begin
      px <= px + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ln <= '0;
    end else if (field_strb) begin
      ln <= '0;
    end else if (line_strb && ln != LN_MAX) begin
      ln <= ln + 1'b1;
    end
  end

endmodule

// File: rtl/pip_inset_win.sv
module pip_inset_win #(
  parameter int H_W = 11,
  parameter int V_W = 9
) (
  input  logic [H_W-1:0] px,
  input  logic [V_W-1:0] ln,
  input  logic [3:0]     off_h,
  input  logic [3:0]     off_v,
  input  logic           en,
  input  logic [7:0]     hpos,
  input  logic [7:0]     vpos,
  input  logic [H_W-1:0] w,
  input  logic [V_W-1:0] h,
  input  logic [2:0]     bw_h,
  input  logic [2:0]     bw_v,
  output logic           hit,
  output logic           rim
);

  localparam int CX = H_W + 3;
  localparam int CY = V_W + 2;

  logic [CX-1:0] x0, x1, xc, bh;
  logic [CY-1:0] y0, y1, yc, bv;
  logic          inside_x, inside_y, live;

  always_comb begin
    x0 = CX'({off_h, 2'b00}) + CX'({hpos, 3'b000});
    x1 = x0 + CX'(w);
    y0 = CY'(off_v) + CY'(vpos);
    y1 = y0 + CY'(h);
    xc = CX'(px);
    yc = CY'(ln);
    bh = CX'({bw_h, 1'b0});
    bv = CY'(bw_v);
  end

  assign live     = en && (w != '0) && (h != '0);
  assign inside_x = (xc >= x0) && (xc < x1);
  assign inside_y = (yc >= y0) && (yc < y1);
  assign hit      = live && inside_x && inside_y;
  assign rim      = hit && ((xc < x0 + bh) || (xc + bh >= x1) ||
                            (yc < y0 + bv) || (yc + bv >= y1));

endmodule

// File: rtl/pip_tint_bank.sv
module pip_tint_bank
  import pip_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] tgt,
  input  logic [1:0] bright,
  input  logic [2:0] hue,
  output tint_t      main_t,
  output tint_t      sub_t,
  output tint_t      bg_t
);

  tint_t wr_val;
  assign wr_val = '{bright: bright, hue: hue};

  always_ff @(posedge clk) begin
    if (rst) begin
      main_t <= '0;
      sub_t  <= '0;
      bg_t   <= '0;
    end else if (we) begin
      case (tgt)
        TGT_MAIN_BDR: main_t <= wr_val;
        TGT_SUB_BDR:  sub_t  <= wr_val;
        TGT_BG:       bg_t   <= wr_val;
        default:      ;
      endcase
    end
  end

endmodule

// File: rtl/pip_blank_align.sv
module pip_blank_align (
  input  logic       clk,
  input  logic       rst,
  input  logic       fbl_early,
  input  logic       fbl_now,
  input  logic [1:0] shift,
  output logic       fbl_out
);

  logic half_late, half_early;

  always_ff @(negedge clk) begin
    if (rst) begin
      half_late  <= 1'b0;
      half_early <= 1'b0;
    end else begin
      half_late  <= fbl_now;
      half_early <= fbl_early;
    end
  end

  always_comb begin
    case (shift)
      2'd0:    fbl_out = fbl_now;
      2'd1:    fbl_out = half_late;
      2'd2:    fbl_out = half_early;
      default: fbl_out = fbl_early;
    endcase
  end

endmodule

// File: rtl/pip_compositor.sv
module pip_compositor
  import pip_pkg::*;
#(
  parameter int H_W  = 11,
  parameter int V_W  = 9,
  parameter int BG_W = 720,
  parameter int BG_H = 240
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           line_strb,
  input  logic           field_strb,
  input  logic [3:0]     off_h,
  input  logic [3:0]     off_v,
  input  logic           main_en,
  input  logic [7:0]     main_hpos,
  input  logic [7:0]     main_vpos,
  input  logic [H_W-1:0] main_w,
  input  logic [V_W-1:0] main_h,
  input  logic           sub_en,
  input  logic [7:0]     sub_hpos,
  input  logic [7:0]     sub_vpos,
  input  logic [H_W-1:0] sub_w,
  input  logic [V_W-1:0] sub_h,
  input  logic           prio,
  input  logic           bg_en,
  input  logic           bw_we,
  input  logic [2:0]     bw_h,
  input  logic [2:0]     bw_v,
  input  logic           col_we,
  input  logic [1:0]     col_sel,
  input  logic [1:0]     col_bright,
  input  logic [2:0]     col_hue,
  input  logic [1:0]     blank_shift,
  output logic [2:0]     ovl_sel,
  output logic           ovl_fbl,
  output logic [1:0]     ovl_bright,
  output logic [2:0]     ovl_hue
);

  localparam int N_INSET = 2;
  localparam int CX = H_W + 3;
  localparam int CY = V_W + 2;

  logic [H_W-1:0] px;
  logic [V_W-1:0] ln;

  pip_raster_cnt #(.H_W(H_W), .V_W(V_W)) u_cnt (
    .clk(clk), .rst(rst), .line_strb(line_strb), .field_strb(field_strb),
    .px(px), .ln(ln)
  );

  // border thickness registers
  logic [2:0] bwh_q, bwv_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      bwh_q <= BW_H_RST;
      bwv_q <= BW_V_RST;
    end else if (bw_we) begin
      bwh_q <= bw_h;
      bwv_q <= bw_v;
    end
  end

  // inset windows, index 0 = main, 1 = sub
  logic           ins_en   [N_INSET];
  logic [7:0]     ins_hpos [N_INSET];
  logic [7:0]     ins_vpos [N_INSET];
  logic [H_W-1:0] ins_w    [N_INSET];
  logic [V_W-1:0] ins_h    [N_INSET];
  logic [N_INSET-1:0] hit, rim;

  always_comb begin
    ins_en[0] = main_en;  ins_hpos[0] = main_hpos; ins_vpos[0] = main_vpos;
    ins_w[0]  = main_w;   ins_h[0]    = main_h;
    ins_en[1] = sub_en;   ins_hpos[1] = sub_hpos;  ins_vpos[1] = sub_vpos;
    ins_w[1]  = sub_w;    ins_h[1]    = sub_h;
  end

  for (genvar gi = 0; gi < N_INSET; gi++) begin : g_win
    pip_inset_win #(.H_W(H_W), .V_W(V_W)) u_win (
      .px(px), .ln(ln), .off_h(off_h), .off_v(off_v),
      .en(ins_en[gi]), .hpos(ins_hpos[gi]), .vpos(ins_vpos[gi]),
      .w(ins_w[gi]), .h(ins_h[gi]), .bw_h(bwh_q), .bw_v(bwv_q),
      .hit(hit[gi]), .rim(rim[gi])
    );
  end

  // background area
  logic [CX-1:0] bx0, bx1, bxc;
  logic [CY-1:0] by0, by1, byc;
  logic          bg_hit;

  always_comb begin
    bx0 = CX'({off_h, 2'b00});
    bx1 = bx0 + CX'(BG_W);
    by0 = CY'(off_v);
    by1 = by0 + CY'(BG_H);
    bxc = CX'(px);
    byc = CY'(ln);
    bg_hit = bg_en && (bxc >= bx0) && (bxc < bx1) && (byc >= by0) && (byc < by1);
  end

  // layering
  ovl_sel_e cls;
  logic     sub_on_top;

  always_comb begin
    sub_on_top = hit[1] && (!hit[0] || prio);
    if (sub_on_top)       cls = rim[1] ? SEL_SUB_BDR : SEL_SUB;
    else if (hit[0])      cls = rim[0] ? SEL_MAIN_BDR : SEL_MAIN;
    else if (bg_hit)      cls = SEL_BG;
    else                  cls = SEL_PASS;
  end

  // colour registers
  tint_t main_t, sub_t, bg_t, tint_nx;

  pip_tint_bank u_tint (
    .clk(clk), .rst(rst), .we(col_we), .tgt(col_sel),
    .bright(col_bright), .hue(col_hue),
    .main_t(main_t), .sub_t(sub_t), .bg_t(bg_t)
  );

  // stage A: layer decision, one pixel ahead of the outputs
  ovl_sel_e sel_a;
  logic     fbl_a;

  always_ff @(posedge clk) begin
    if (rst) sel_a <= SEL_PASS;
    else     sel_a <= cls;
  end

  assign fbl_a = (sel_a != SEL_PASS);

  always_comb begin
    case (sel_a)
      SEL_BG:       tint_nx = bg_t;
      SEL_MAIN_BDR: tint_nx = main_t;
      SEL_SUB_BDR:  tint_nx = sub_t;
      default:      tint_nx = '0;
    endcase
  end

  // stage B: registered outputs
  ovl_sel_e sel_q;
  tint_t    tint_q;
  logic     fbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_PASS;
      tint_q <= '0;
      fbl_q  <= 1'b0;
    end else begin
      sel_q  <= sel_a;
      tint_q <= tint_nx;
      fbl_q  <= fbl_a;
    end
  end

  pip_blank_align u_blank (
    .clk(clk), .rst(rst), .fbl_early(fbl_a), .fbl_now(fbl_q),
    .shift(blank_shift), .fbl_out(ovl_fbl)
  );

  assign ovl_sel    = sel_q;
  assign ovl_bright = tint_q.bright;
  assign ovl_hue    = tint_q.hue;

endmodule

// File: rtl/pip_compositor_chk.sv
module pip_compositor_chk #(
  parameter int H_W = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           line_strb,
  input logic [1:0]     blank_shift,
  input logic [2:0]     ovl_sel,
  input logic           ovl_fbl,
  input logic [1:0]     ovl_bright,
  input logic [2:0]     ovl_hue,
  input logic [H_W-1:0] px,
  input logic           fbl_now
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      // R1
      rst_state_chk: assert (ovl_sel == 3'd0 && ovl_bright == 2'd0 && ovl_hue == 3'd0);
    end
  end

  // R2
  line_zero_chk: assert property (@(posedge clk) disable iff (rst)
    line_strb |=> px == '0);

  // R9
  sel_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ovl_sel <= 3'd5);

  // R9
  fbl_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_shift == 2'd0) |-> (ovl_fbl == (ovl_sel != 3'd0)));

  // R10
  tint_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ovl_sel == 3'd0 || ovl_sel == 3'd2 || ovl_sel == 3'd3) |->
      (ovl_bright == 2'd0 && ovl_hue == 3'd0));

  // R12
  lead_one_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_shift == 2'd3) |=> (fbl_now == $past(ovl_fbl)));

endmodule

bind pip_compositor pip_compositor_chk #(.H_W(H_W)) u_chk (
  .clk(clk), .rst(rst), .line_strb(line_strb), .blank_shift(blank_shift),
  .ovl_sel(ovl_sel), .ovl_fbl(ovl_fbl), .ovl_bright(ovl_bright),
  .ovl_hue(ovl_hue), .px(px), .fbl_now(fbl_q)
);

// File: tb/tb_pip_compositor.sv
module tb_pip_compositor;

  localparam int H_W = 11;
  localparam int V_W = 9;
  localparam int BGW = 40;
  localparam int BGH = 14;
  localparam int NL  = 20;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst, line_strb, field_strb;
  logic [3:0]     off_h, off_v;
  logic           main_en, sub_en, prio, bg_en;
  logic [7:0]     main_hpos, main_vpos, sub_hpos, sub_vpos;
  logic [H_W-1:0] main_w, sub_w;
  logic [V_W-1:0] main_h, sub_h;
  logic           bw_we, col_we;
  logic [2:0]     bw_h, bw_v, col_hue;
  logic [1:0]     col_sel, col_bright, blank_shift;
  logic [2:0]     ovl_sel;
  logic           ovl_fbl;
  logic [1:0]     ovl_bright;
  logic [2:0]     ovl_hue;

  pip_compositor #(.H_W(H_W), .V_W(V_W), .BG_W(BGW), .BG_H(BGH)) dut (
    .clk(clk), .rst(rst), .line_strb(line_strb), .field_strb(field_strb),
    .off_h(off_h), .off_v(off_v),
    .main_en(main_en), .main_hpos(main_hpos), .main_vpos(main_vpos),
    .main_w(main_w), .main_h(main_h),
    .sub_en(sub_en), .sub_hpos(sub_hpos), .sub_vpos(sub_vpos),
    .sub_w(sub_w), .sub_h(sub_h),
    .prio(prio), .bg_en(bg_en), .bw_we(bw_we), .bw_h(bw_h), .bw_v(bw_v),
    .col_we(col_we), .col_sel(col_sel), .col_bright(col_bright), .col_hue(col_hue),
    .blank_shift(blank_shift),
    .ovl_sel(ovl_sel), .ovl_fbl(ovl_fbl), .ovl_bright(ovl_bright), .ovl_hue(ovl_hue)
  );

  int checks = 0;
  int fails  = 0;
  int valid  = 0;
  string tag = "R1";
  int hx[4];
  int hy[4];
  int mx = 0, my = 0;
  int m_bwh = 2, m_bwv = 2;
  int m_tint[3] = '{0, 0, 0};  // main border, sub border, background

  function automatic int win(int x, int y, int ox, int oy, int w, int h, int en);
    if (en == 0 || w == 0 || h == 0) return 0;
    if (x < ox || x >= ox + w || y < oy || y >= oy + h) return 0;
    if ((x - ox) < 2 * m_bwh || (ox + w - 1 - x) < 2 * m_bwh ||
        (y - oy) < m_bwv || (oy + h - 1 - y) < m_bwv) return 2;
    return 1;
  endfunction

  function automatic int cls(int x, int y);
    int m, s;
    m = win(x, y, 4 * off_h + 8 * main_hpos, off_v + main_vpos, main_w, main_h, main_en);
    s = win(x, y, 4 * off_h + 8 * sub_hpos, off_v + sub_vpos, sub_w, sub_h, sub_en);
    if (s != 0 && (m == 0 || prio)) return (s == 2) ? 5 : 3;
    if (m != 0) return (m == 2) ? 4 : 2;
    if (bg_en && x >= 4 * off_h && x < 4 * off_h + BGW && y >= off_v && y < off_v + BGH)
      return 1;
    return 0;
  endfunction

  function automatic int tintv(int s);
    case (s)
      1: return m_tint[2];
      4: return m_tint[0];
      5: return m_tint[1];
      default: return 0;
    endcase
  endfunction

  function automatic int fb(int k);
    return (cls(hx[k], hy[k]) != 0) ? 1 : 0;
  endfunction

  task automatic chk_fbl(int exp_v, string half);
    string t;
    t = (blank_shift == 2'd0) ? "R9" : "R12";
    checks++;
    if (int'(ovl_fbl) != exp_v) begin
      fails++;
      $display("FAIL %s fbl %s half shift=%0d x=%0d y=%0d: got %0d exp %0d",
               t, half, blank_shift, hx[2], hy[2], ovl_fbl, exp_v);
    end
  endtask

  task automatic tick(logic ls, logic fs);
    int e;
    line_strb  = ls;
    field_strb = fs;
    @(posedge clk);
    if (ls) mx = 0; else if (mx < 2047) mx++;
    if (fs) my = 0; else if (ls && my < 511) my++;
    for (int k = 3; k > 0; k--) begin
      hx[k] = hx[k-1];
      hy[k] = hy[k-1];
    end
    hx[0] = mx;
    hy[0] = my;
    valid++;
    #2;
    line_strb  = 1'b0;
    field_strb = 1'b0;
    if (valid >= 5) begin
      e = cls(hx[2], hy[2]);
      checks++;
      if (int'(ovl_sel) != e || int'({ovl_bright, ovl_hue}) != tintv(e)) begin
        fails++;
        $display("FAIL %s x=%0d y=%0d: got sel=%0d tint=%0d exp sel=%0d tint=%0d",
                 tag, hx[2], hy[2], ovl_sel, {ovl_bright, ovl_hue}, e, tintv(e));
      end
      case (blank_shift)
        2'd0: chk_fbl(fb(2), "first");
        2'd1: chk_fbl(fb(3), "first");
        2'd2: chk_fbl(fb(2), "first");
        default: chk_fbl(fb(1), "first");
      endcase
      #4;
      case (blank_shift)
        2'd0: chk_fbl(fb(2), "second");
        2'd1: chk_fbl(fb(2), "second");
        2'd2: chk_fbl(fb(1), "second");
        default: chk_fbl(fb(1), "second");
      endcase
    end else begin
      #4;
    end
  endtask

  task automatic scn(string t, int len);
    tag = t;
    valid = 0;
    repeat (5) tick(1'b0, 1'b0);
    for (int l = 0; l < NL; l++) begin
      tick(1'b1, l == 0);
      repeat (len - 1) tick(1'b0, 1'b0);
    end
  endtask

  // R11
  task automatic set_border(int bh, int bv);
    valid = 0;
    bw_we = 1'b1; bw_h = 3'(bh); bw_v = 3'(bv);
    tick(1'b0, 1'b0);
    bw_we = 1'b0;
    if (1) begin m_bwh = bh; m_bwv = bv; end
  endtask

  // R10
  task automatic set_tint(int tgt, int br, int hu);
    valid = 0;
    col_we = 1'b1; col_sel = 2'(tgt); col_bright = 2'(br); col_hue = 3'(hu);
    tick(1'b0, 1'b0);
    col_we = 1'b0;
    if (tgt < 3) m_tint[tgt] = br * 8 + hu;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) begin hx[k] = 0; hy[k] = 0; end
    rst = 1'b1; line_strb = 0; field_strb = 0;
    off_h = 0; off_v = 0; main_en = 0; sub_en = 0; prio = 0; bg_en = 0;
    main_hpos = 0; main_vpos = 0; sub_hpos = 0; sub_vpos = 0;
    main_w = 0; main_h = 0; sub_w = 0; sub_h = 0;
    bw_we = 0; bw_h = 0; bw_v = 0; col_we = 0; col_sel = 0; col_bright = 0; col_hue = 0;
    blank_shift = 0;
    repeat (3) begin
      @(posedge clk); #2;
      checks++;
      if (ovl_sel !== 3'd0 || ovl_fbl !== 1'b0 || ovl_bright !== 2'd0 || ovl_hue !== 3'd0) begin
        fails++;
        $display("FAIL R1 reset outputs: got sel=%0d fbl=%0d br=%0d hue=%0d exp all 0",
                 ovl_sel, ovl_fbl, ovl_bright, ovl_hue);
      end
    end
    #4 rst = 1'b0;

    // R1: default border thickness, main inset only
    main_en = 1; main_hpos = 1; main_vpos = 2; main_w = 20; main_h = 10;
    scn("R1", 64);
    // R2: other line length
    scn("R2", 50);
    // R3: offsets move the main inset
    off_h = 3; off_v = 1; main_hpos = 2; main_vpos = 3; main_w = 17; main_h = 9;
    scn("R3", 64);
    // R11: border thickness written
    set_border(1, 3);
    scn("R11", 64);
    // R5: no border, then border covering the whole window
    set_border(0, 0);
    scn("R5", 64);
    main_w = 12; main_h = 8;
    set_border(7, 7);
    scn("R5", 64);
    set_border(2, 1);
    // R4: sub inset only
    off_h = 1; off_v = 0;
    main_en = 0; sub_en = 1; sub_hpos = 3; sub_vpos = 4; sub_w = 21; sub_h = 7;
    scn("R4", 64);
    // R6: overlap, both priorities
    main_en = 1; main_hpos = 1; main_vpos = 2; main_w = 20; main_h = 10;
    sub_hpos = 2; sub_vpos = 5; sub_w = 20; sub_h = 9;
    prio = 0;
    scn("R6", 64);
    prio = 1;
    scn("R6", 64);
    // R8: background only
    main_en = 0; sub_en = 0; bg_en = 1; off_h = 2; off_v = 3;
    scn("R8", 64);
    // R7: zero sizes or disabled insets suppressed
    main_en = 1; main_w = 20; main_h = 0; sub_en = 0; sub_w = 20;
    scn("R7", 64);
    main_w = 0; main_h = 10; sub_en = 1; sub_w = 0;
    scn("R7", 64);
    // R10: colour registers, select 3 writes nothing
    main_w = 20; sub_w = 20; off_h = 0; off_v = 0;
    set_tint(0, 2, 5);
    set_tint(1, 1, 3);
    set_tint(2, 3, 6);
    set_tint(3, 0, 7);
    scn("R10", 64);
    // R12: blanking shift codes
    for (int s = 0; s < 4; s++) begin
      blank_shift = 2'(s);
      scn("R12", 64);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule